// File: doc/BRIEF.md
# Instruction Step Sequencer with Return-from-Trap Legality Check

This block decides, once per clock, how the program counter pair advances in a processor with delayed control transfers. It holds the current fetch address (`pc`) and the address that follows it (`npc`). Each cycle it picks one of several step kinds: trap entry, hold, fetch fault, skip of an annulled delay slot, sequential advance, a loaded control transfer, or a refused return-from-trap. It then updates the pair to match. Decode and the datapath sit outside. They supply flags for a pending trap, execute mode, annul state, control transfer and return-from-trap, plus the transfer targets and the processor status fields.

A return-from-trap request is judged against the trap-enable bit, the supervisor bit, the window invalid mask at the window above the current one, and the alignment of the target. The checks run in a fixed order, and the first one that fails sets a 2-bit reason code. A legal return performs a delayed jump: `pc` takes `npc` and `npc` takes the target. A refused return leaves the pair untouched and raises `rett_fault`.

Top module: `step_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc` becomes 0 and `npc` becomes 4.
- R2: When `trap_pend` is 1, `trap_enter` is 1, every other status output is 0, and `pc` and `npc` keep their values. A pending trap takes priority over all other inputs.
- R3: When `trap_pend` is 0 and `exec_en` is 0, all status outputs are 0 and `pc` and `npc` keep their values.
- R4: When executing with `pc[1:0]` nonzero, `fetch_fault` is 1 and `pc` and `npc` keep their values. This check takes priority over annul, transfer and return.
- R5: When executing with an aligned `pc` and `annul_in` at 1, `annul_clr` is 1, `pc` takes `npc` and `npc` takes `npc`+4. Any transfer or return request in that cycle is ignored.
- R6: An executed step with no annul, no transfer and no return sets `pc` to `npc` and `npc` to `npc`+4.
- R7: An executed step with `ctl_xfer` at 1 (and no return request) loads `pc` from `xfer_pc` and `npc` from `xfer_npc`.
- R8: A judged return with `psr_et`=1 is legal, whatever the other fields hold: `rett_ok`=1 and `rett_code`=0.
- R9: A judged return with `psr_et`=0 and `psr_s`=0 is refused with code 1. This holds regardless of the mask and the target.
- R10: Otherwise, if bit ((`psr_cwp`+1) mod NWIN) of `wim` is 1, the return is refused with code 2. At `psr_cwp`=NWIN-1 this index wraps to bit 0.
- R11: Otherwise, if `rett_target[1:0]` is nonzero, the return is refused with code 3. If none of the checks fail, the code is 0.
- R12: A legal return sets `pc` to `npc` and `npc` to `rett_target`. A refused return sets `rett_fault` and keeps `pc` and `npc`. Outside a judged return, `rett_ok`, `rett_fault` and `rett_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_pend | input | 1 | A trap is pending |
| exec_en | input | 1 | Processor is in execute mode |
| annul_in | input | 1 | Current instruction is an annulled delay slot |
| ctl_xfer | input | 1 | Instruction is a call, jump or branch that supplies its own targets |
| xfer_pc | input | AW (32) | New `pc` for a control transfer |
| xfer_npc | input | AW (32) | New `npc` for a control transfer |
| rett_req | input | 1 | Instruction is a return-from-trap |
| rett_target | input | AW (32) | Return target address |
| psr_et | input | 1 | Trap-enable bit |
| psr_s | input | 1 | Supervisor bit |
| psr_cwp | input | CW (3) | Current window pointer |
| wim | input | NWIN (8) | Window invalid mask |
| pc | output | AW (32) | Current fetch address |
| npc | output | AW (32) | Next fetch address |
| trap_enter | output | 1 | Start trap entry this cycle |
| fetch_fault | output | 1 | Misaligned fetch exception |
| annul_clr | output | 1 | Clear the annul state |
| rett_ok | output | 1 | Return-from-trap accepted |
| rett_fault | output | 1 | Return-from-trap refused |
| rett_code | output | 2 | Refusal reason: 0 none, 1 not supervisor, 2 window invalid, 3 misaligned target |

## Verification
Several inputs can land in the same cycle. The main collision is a pending trap together with an annul or a return-from-trap request. A second one is an annulled slot whose instruction is itself a return or a transfer. The random stimulus sets these flags independently, so they overlap often. Directed cycles also raise trap, annul and a faulty return together, and then annul with a faulty return. In each case the bench checks that only the higher-priority action shows on the status outputs and in the next `pc`/`npc`. A refused return must leave no trace while annul or trap wins.

// File: rtl/step_pkg.sv
package step_pkg;
  typedef enum logic [2:0] {
    STEP_HOLD  = 3'd0,
    STEP_TRAP  = 3'd1,
    STEP_FAULT = 3'd2,
    STEP_SKIP  = 3'd3,
    STEP_SEQ   = 3'd4,
    STEP_LOAD  = 3'd5,
    STEP_RETT  = 3'd6,
    STEP_REFUSE = 3'd7
  } step_kind_e;

  localparam logic [1:0] RC_NONE    = 2'd0;
  localparam logic [1:0] RC_USER    = 2'd1;
  localparam logic [1:0] RC_WINDOW  = 2'd2;
  localparam logic [1:0] RC_ALIGN   = 2'd3;
endpackage

// File: rtl/rett_judge.sv
module rett_judge #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk,
  input  logic            et,
  input  logic            s,
  input  logic [CW-1:0]   cwp,
  input  logic [NWIN-1:0] wim,
  input  logic [1:0]      tgt_lo,
  output logic            bad,
  output logic [1:0]      code
);
  import step_pkg::*;

  function automatic logic [CW-1:0] win_above(input logic [CW-1:0] w);
    if (int'(w) >= NWIN - 1) return '0;
    return w + 1'b1;
  endfunction

  logic [CW-1:0] above_idx;
  logic          above_invalid;
  logic [1:0]    raw_code;

  assign above_idx     = win_above(cwp);
  assign above_invalid = wim[above_idx];

  always_comb begin
    if (et)                  raw_code = RC_NONE;
    else if (!s)             raw_code = RC_USER;
    else if (above_invalid)  raw_code = RC_WINDOW;
    else if (tgt_lo != 2'b00) raw_code = RC_ALIGN;
    else                     raw_code = RC_NONE;
  end

  assign code = chk ? raw_code : RC_NONE;
  assign bad  = chk && (raw_code != RC_NONE);

  p_et_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && et) |-> (!bad && code == RC_NONE));
  p_user_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !et && !s) |-> (bad && code == RC_USER));
  p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !et && s && above_invalid) |-> (code == RC_WINDOW));
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !chk |-> (!bad && code == RC_NONE));
endmodule

// File: rtl/step_decide.sv
module step_decide #(
  parameter int AW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trap_pend,
  input  logic                  exec_en,
  input  logic                  annul_in,
  input  logic                  ctl_xfer,
  input  logic                  rett_req,
  input  logic [1:0]            pc_lo,
  input  logic                  rett_bad,
  output logic                  rett_chk,
  output step_pkg::step_kind_e  kind
);
  import step_pkg::*;

  logic misaligned;
  assign misaligned = (pc_lo != 2'b00);
  assign rett_chk   = !trap_pend && exec_en && !misaligned && !annul_in && rett_req;

  always_comb begin
    if (trap_pend)       kind = STEP_TRAP;
    else if (!exec_en)   kind = STEP_HOLD;
    else if (misaligned) kind = STEP_FAULT;
    else if (annul_in)   kind = STEP_SKIP;
    else if (rett_req)   kind = rett_bad ? STEP_REFUSE : STEP_RETT;
    else if (ctl_xfer)   kind = STEP_LOAD;
    else                 kind = STEP_SEQ;
  end

  p_trap_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pend |-> (kind == STEP_TRAP && !rett_chk));
  p_annul_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_SKIP) |-> !rett_chk);
endmodule

// File: rtl/pc_regs.sv
module pc_regs #(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  step_pkg::step_kind_e kind,
  input  logic [AW-1:0]        xfer_pc,
  input  logic [AW-1:0]        xfer_npc,
  input  logic [AW-1:0]        rett_target,
  output logic [AW-1:0]        pc,
  output logic [AW-1:0]        npc
);
  import step_pkg::*;

  localparam logic [AW-1:0] WORD     = AW'(4);
  localparam logic [AW-1:0] PC_RESET = '0;

  function automatic logic [AW-1:0] after(input logic [AW-1:0] a);
    return a + WORD;
  endfunction

  logic [AW-1:0] pc_d, npc_d;

  always_comb begin
    pc_d  = pc;
    npc_d = npc;
    unique case (kind)
      STEP_SKIP, STEP_SEQ: begin pc_d = npc;     npc_d = after(npc);  end
      STEP_LOAD:           begin pc_d = xfer_pc; npc_d = xfer_npc;    end
      STEP_RETT:           begin pc_d = npc;     npc_d = rett_target; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= PC_RESET;
      npc <= after(PC_RESET);
    end else begin
      pc  <= pc_d;
      npc <= npc_d;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && npc == WORD));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_HOLD || kind == STEP_TRAP || kind == STEP_FAULT || kind == STEP_REFUSE)
    |=> ($stable(pc) && $stable(npc)));
  p_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_SEQ || kind == STEP_SKIP) |=> (pc == $past(npc) && npc == $past(npc) + WORD));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_LOAD) |=> (pc == $past(xfer_pc) && npc == $past(xfer_npc)));
  p_rett_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == STEP_RETT) |=> (pc == $past(npc) && npc == $past(rett_target)));
endmodule

// File: rtl/step_unit.sv
module step_unit #(
  parameter int AW   = 32,
  parameter int NWIN = 8,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_pend,
  input  logic            exec_en,
  input  logic            annul_in,
  input  logic            ctl_xfer,
  input  logic [AW-1:0]   xfer_pc,
  input  logic [AW-1:0]   xfer_npc,
  input  logic            rett_req,
  input  logic [AW-1:0]   rett_target,
  input  logic            psr_et,
  input  logic            psr_s,
  input  logic [CW-1:0]   psr_cwp,
  input  logic [NWIN-1:0] wim,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   npc,
  output logic            trap_enter,
  output logic            fetch_fault,
  output logic            annul_clr,
  output logic            rett_ok,
  output logic            rett_fault,
  output logic [1:0]      rett_code
);
  import step_pkg::*;

  step_kind_e kind;
  logic       rett_chk;
  logic       rett_bad;

  step_decide #(.AW(AW)) u_decide (
    .clk(clk), .rst_n(rst_n),
    .trap_pend(trap_pend), .exec_en(exec_en), .annul_in(annul_in),
    .ctl_xfer(ctl_xfer), .rett_req(rett_req), .pc_lo(pc[1:0]),
    .rett_bad(rett_bad), .rett_chk(rett_chk), .kind(kind)
  );

  rett_judge #(.NWIN(NWIN), .AW(AW)) u_judge (
    .clk(clk), .rst_n(rst_n), .chk(rett_chk),
    .et(psr_et), .s(psr_s), .cwp(psr_cwp), .wim(wim),
    .tgt_lo(rett_target[1:0]), .bad(rett_bad), .code(rett_code)
  );

  pc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .xfer_pc(xfer_pc), .xfer_npc(xfer_npc), .rett_target(rett_target),
    .pc(pc), .npc(npc)
  );

  assign trap_enter  = (kind == STEP_TRAP);
  assign fetch_fault = (kind == STEP_FAULT);
  assign annul_clr   = (kind == STEP_SKIP);
  assign rett_ok     = (kind == STEP_RETT);
  assign rett_fault  = (kind == STEP_REFUSE);

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_enter, fetch_fault, annul_clr, rett_ok, rett_fault}));
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |=> ($stable(pc) && $stable(npc)));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_pend && !exec_en) |-> !(trap_enter || fetch_fault || annul_clr || rett_ok || rett_fault));
endmodule

// File: tb/sim_step_unit.sv
module sim_step_unit;
  localparam int AW = 32;
  localparam int NWIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_pend = 0, exec_en = 0, annul_in = 0, ctl_xfer = 0, rett_req = 0;
  logic psr_et = 0, psr_s = 0;
  logic [2:0] psr_cwp = '0;
  logic [NWIN-1:0] wim = '0;
  logic [AW-1:0] xfer_pc = '0, xfer_npc = '0, rett_target = '0;
  logic [AW-1:0] pc, npc;
  logic trap_enter, fetch_fault, annul_clr, rett_ok, rett_fault;
  logic [1:0] rett_code;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_pc, m_npc;

  always #2 clk = ~clk;

  step_unit #(.AW(AW), .NWIN(NWIN)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic et, input logic s, input logic [2:0] cwp,
                                          input logic [NWIN-1:0] m, input logic [1:0] lo);
    int idx;
    idx = (int'(cwp) + 1) % NWIN;
    if (et) return 2'd0;
    if (!s) return 2'd1;
    if (m[idx]) return 2'd2;
    if (lo != 2'b00) return 2'd3;
    return 2'd0;
  endfunction

  // One clock step: inputs are already set (at a falling edge).
  task automatic cyc();
    bit e_trap, e_fault, e_skip, judged, e_ok, e_ref;
    logic [1:0] e_code;
    logic [AW-1:0] n_pc, n_npc;
    string tag;
    #0.5;
    n_pc = m_pc; n_npc = m_npc;
    if (!rst_n) begin
      n_pc = 0; n_npc = 4;
    end else begin
      e_trap  = trap_pend;
      e_fault = !trap_pend && exec_en && (m_pc[1:0] != 0);
      e_skip  = !trap_pend && exec_en && !e_fault && annul_in;
      judged  = !trap_pend && exec_en && !e_fault && !annul_in && rett_req;
      e_code  = judged ? exp_code(psr_et, psr_s, psr_cwp, wim, rett_target[1:0]) : 2'd0;
      e_ok    = judged && e_code == 0;
      e_ref   = judged && e_code != 0;
      tag = trap_pend ? "R2" : (!exec_en ? "R3" : "R4");
      check(trap_enter == e_trap, tag, trap_enter, e_trap);
      check(fetch_fault == e_fault, "R4", fetch_fault, e_fault);
      check(annul_clr == e_skip, "R5", annul_clr, e_skip);
      check(rett_ok == e_ok, psr_et ? "R8" : "R12", rett_ok, e_ok);
      check(rett_fault == e_ref, "R12", rett_fault, e_ref);
      tag = (e_code == 1) ? "R9" : (e_code == 2) ? "R10" : (e_code == 3) ? "R11" : "R8";
      check(rett_code == e_code, tag, rett_code, e_code);
      if (e_skip || (exec_en && !trap_pend && !e_fault && !rett_req && !ctl_xfer)) begin
        n_pc = m_npc; n_npc = m_npc + 4;
      end else if (e_ok) begin
        n_pc = m_npc; n_npc = rett_target;
      end else if (exec_en && !trap_pend && !e_fault && !rett_req && ctl_xfer) begin
        n_pc = xfer_pc; n_npc = xfer_npc;
      end
    end
    @(negedge clk);
    m_pc = n_pc; m_npc = n_npc;
    tag = !rst_n ? "R1" : "R6";
    check(pc == m_pc, tag, pc, m_pc);
    check(npc == m_npc, tag, npc, m_npc);
  endtask

  task automatic quiet();
    trap_pend = 0; exec_en = 1; annul_in = 0; ctl_xfer = 0; rett_req = 0;
  endtask

  task automatic rett_case(input logic et, input logic s, input logic [2:0] cwp,
                           input logic [NWIN-1:0] m, input logic [AW-1:0] tgt);
    quiet(); rett_req = 1; psr_et = et; psr_s = s; psr_cwp = cwp; wim = m; rett_target = tgt;
    cyc();
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    m_pc = 0; m_npc = 0;
    @(negedge clk);
    rst_n = 0; cyc();            // R1 reset values
    rst_n = 1;
    quiet(); cyc(); cyc();       // R6 sequential
    quiet(); exec_en = 0; cyc(); // R3 hold
    quiet(); annul_in = 1; cyc(); // R5 skip
    quiet(); ctl_xfer = 1; xfer_pc = 32'h100; xfer_npc = 32'h200; cyc(); // R7
    rett_case(1, 0, 3'd7, 8'hFF, 32'h3);        // R8 ET overrides all
    rett_case(0, 0, 3'd2, 8'hFF, 32'h1);        // R9 first check
    rett_case(0, 1, 3'd7, 8'h01, 32'h2);        // R10 wrap to bit 0
    rett_case(0, 1, 3'd7, 8'h80, 32'h2);        // R11 bit 7 not used at cwp 7
    rett_case(0, 1, 3'd1, 8'h04, 32'h0);        // R10
    rett_case(0, 1, 3'd1, 8'hFB, 32'h400);      // R12 legal
    // collisions: trap + annul + bad return, then annul + bad return
    quiet(); trap_pend = 1; annul_in = 1; rett_req = 1; psr_et = 0; psr_s = 0; cyc();
    quiet(); annul_in = 1; rett_req = 1; psr_et = 0; psr_s = 0; cyc();
    // R4 misaligned fetch
    quiet(); ctl_xfer = 1; xfer_pc = 32'h102; xfer_npc = 32'h106; cyc();
    quiet(); annul_in = 1; rett_req = 1; cyc();
    rst_n = 0; quiet(); cyc(); rst_n = 1;

    for (int i = 0; i < 4000; i++) begin
      trap_pend = ($urandom_range(9) == 0);
      exec_en   = ($urandom_range(9) != 0);
      annul_in  = ($urandom_range(4) == 0);
      ctl_xfer  = ($urandom_range(2) == 0);
      rett_req  = ($urandom_range(4) == 0);
      psr_et    = ($urandom_range(2) == 0);
      psr_s     = ($urandom_range(3) != 0);
      psr_cwp   = 3'($urandom_range(7));
      wim       = 8'($urandom) & 8'($urandom);
      xfer_pc   = {$urandom} & 32'hFFFF_FFFC | 32'($urandom_range(15) == 0);
      xfer_npc  = {$urandom};
      rett_target = {$urandom} & (($urandom_range(3) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC);
      cyc();
      if (m_pc[1:0] != 0) begin
        quiet(); cyc();          // R4 fault holds
        rst_n = 0; cyc(); rst_n = 1;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule